// File: doc/BRIEF.md
# Windowed Register File with Window Traps

This block is the integer register file of a processor that uses overlapping register windows. Physical storage holds eight global registers and a ring of windows, each of which adds sixteen registers. A current window pointer decides which physical registers the 32 architectural register numbers reach. Two read ports and one write port take 5-bit architectural addresses. Reads are combinational. Writes take effect at the clock edge.

A save command moves the pointer to the window that receives the callee's frame. A restore command moves it back. Because the windows overlap, the values a caller places in its outgoing registers show up in the callee's incoming registers without any copy. An invalid-window mask, with one bit per window, marks windows that must not be entered. A save or restore that would land on a marked window does not move the pointer. Instead it raises a one-cycle overflow or underflow trap, and the trap handler then deals with the spill or fill.

Top module: `winreg_file`

## Requirements
- R1: After a synchronous active-low reset, the window pointer is 0, the mask is all zeros, both trap outputs are low, and every register reads 0.
- R2: Architectural register 0 always reads 0. A write to it is discarded, and this includes the cycle of the write itself.
- R3: Architectural registers 1 to 7 are globals. They hold one value that is seen from every window.
- R4: Registers 8 to 31 of window w map to physical index 8 + ((16·w + r − 8) mod (16·NWIN)). As a result, locals 16 to 23 are private to each window, and a write in one window's locals is not seen in another window.
- R5: The incoming registers 24+k of window w are the same storage as the outgoing registers 8+k of window w+1 (mod NWIN). After a save, the callee reads the caller's outgoing values in registers 24 to 31.
- R6: A save with no trap sets the pointer to (cwp − 1) mod NWIN, so 0 goes to NWIN−1. A restore with no trap sets it to (cwp + 1) mod NWIN. With neither command, the pointer holds.
- R7: A save whose target window has its mask bit set leaves the pointer unchanged. It drives trap_overflow high for exactly the one cycle after the command edge.
- R8: A restore whose target window has its mask bit set leaves the pointer unchanged. It drives trap_underflow high for exactly the one cycle after the command edge.
- R9: When save and restore are asserted together, only the save is carried out (including its trap check), and the restore is dropped.
- R10: A read of the register being written in the same cycle returns the new write data.
- R11: A write issued in the same cycle as a save or restore goes to the window that was current before the pointer moves.
- R12: A mask load (mask bit i guards window i) takes effect at its clock edge. A save or restore in the same cycle is checked against the old mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_addr_a | input | 5 | Read port A architectural register number |
| rd_data_a | output | DW | Read port A data (combinational) |
| rd_addr_b | input | 5 | Read port B architectural register number |
| rd_data_b | output | DW | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write architectural register number |
| wr_data | input | DW | Write data |
| save_req | input | 1 | Move to the callee window (pointer decrement) |
| restore_req | input | 1 | Move back to the caller window (pointer increment) |
| mask_we | input | 1 | Load the invalid-window mask |
| mask_wdata | input | NWIN | New mask value, bit i guards window i |
| cwp | output | 5 | Current window pointer |
| trap_overflow | output | 1 | One-cycle pulse: a save was refused |
| trap_underflow | output | 1 | One-cycle pulse: a restore was refused |

## Verification
A wrong window pointer shows up at the cwp port one cycle after the save or restore that caused it. It also shows in the read data in that same cycle, because windowed reads then reach the wrong physical rows. A fault in the overlap arithmetic stays hidden until the first cross-window read: a value written as an outgoing register returns as zero, or as a stale value, from the incoming registers after a save. The bench therefore writes distinct values in every register class before it moves the window. It tests wrap-around in both directions with a non-power-of-two window count, and it checks each trap pulse and the held pointer in the cycle after the command and again in the cycle after that.

// File: rtl/winreg_pkg.sv
// Shared constants and types for the windowed register file.
// Assumes a fixed 32-entry architectural space with 8 globals.
package winreg_pkg;
    localparam int AW       = 5;   // architectural register number width
    localparam int CWP_W    = 5;   // window pointer width (2..32 windows)
    localparam int NGLOB    = 8;   // global registers
    localparam int WIN_REGS = 16;  // physical registers added per window

    // Window movement selected for the current cycle
    typedef enum logic [1:0] {
        MOVE_NONE    = 2'd0,
        MOVE_SAVE    = 2'd1,
        MOVE_RESTORE = 2'd2
    } move_e;
endpackage

// File: rtl/winreg_map.sv
// Maps an architectural register number and window pointer to a physical
// row. Globals map straight through. Windowed registers use one linear
// offset (r - 8) added to 16 * cwp and wrapped over the ring, which makes the
// incoming registers of window w coincide with the outgoing ones of w+1.
// Assumes cwp < NWIN.
module winreg_map
    import winreg_pkg::*;
#(
    parameter int NWIN  = 8,
    parameter int IDX_W = 8
) (
    input  logic [AW-1:0]    arch_addr,
    input  logic [CWP_W-1:0] cwp,
    output logic [IDX_W-1:0] phys_idx
);
    localparam int LIN_W = IDX_W + 1;
    localparam int RING  = WIN_REGS * NWIN;

    logic [LIN_W-1:0] lin_raw;
    logic [LIN_W-1:0] lin_wrap;

    // Compute the ring offset and fold it back once into the ring
    always_comb begin
        lin_raw  = LIN_W'({cwp, 4'b0000}) + LIN_W'(arch_addr) - LIN_W'(NGLOB);
        lin_wrap = (lin_raw >= LIN_W'(RING)) ? (lin_raw - LIN_W'(RING)) : lin_raw;
        if (arch_addr < AW'(NGLOB))
            phys_idx = IDX_W'(arch_addr);
        else
            phys_idx = IDX_W'(lin_wrap + LIN_W'(NGLOB));
    end
endmodule

// File: rtl/winreg_ctrl.sv
// Window pointer and invalid-window mask. Decodes save/restore (save has
// priority), checks the target window against the mask, and either moves
// the pointer or emits a one-cycle trap pulse. Assumes 2 <= NWIN <= 32.
module winreg_ctrl
    import winreg_pkg::*;
#(
    parameter int NWIN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             save_req,
    input  logic             restore_req,
    input  logic             mask_we,
    input  logic [NWIN-1:0]  mask_wdata,
    output logic [CWP_W-1:0] cwp_q,
    output logic             ovf_q,
    output logic             unf_q
);
    localparam int IW = (NWIN > 1) ? $clog2(NWIN) : 1;
    localparam logic [CWP_W-1:0] LAST_WIN = CWP_W'(NWIN - 1);

    logic [NWIN-1:0]  mask_q;
    logic [CWP_W-1:0] cwp_dec;
    logic [CWP_W-1:0] cwp_inc;
    move_e            move;

    // Neighbour windows with wrap modulo the window count
    always_comb begin
        cwp_dec = (cwp_q == '0) ? LAST_WIN : (cwp_q - 1'b1);
        cwp_inc = (cwp_q == LAST_WIN) ? '0 : (cwp_q + 1'b1);
    end

    // Select this cycle's move, save first
    always_comb begin
        move = MOVE_NONE;
        if (save_req)
            move = MOVE_SAVE;
        else if (restore_req)
            move = MOVE_RESTORE;
    end

    // Pointer, mask and trap pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cwp_q  <= '0;
            mask_q <= '0;
            ovf_q  <= 1'b0;
            unf_q  <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
            if (mask_we)
                mask_q <= mask_wdata;
            case (move)
                MOVE_SAVE: begin
                    if (mask_q[cwp_dec[IW-1:0]])
                        ovf_q <= 1'b1;
                    else
                        cwp_q <= cwp_dec;
                end
                MOVE_RESTORE: begin
                    if (mask_q[cwp_inc[IW-1:0]])
                        unf_q <= 1'b1;
                    else
                        cwp_q <= cwp_inc;
                end
                default: ;
            endcase
        end
    end

    assert_cwp_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cwp_q < CWP_W'(NWIN));
    assert_cwp_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!save_req && !restore_req) |=> $stable(cwp_q));
    assert_overflow_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> ($past(save_req) && $stable(cwp_q)));
    assert_underflow_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        unf_q |-> ($past(restore_req) && !$past(save_req) && $stable(cwp_q)));
    assert_single_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ovf_q, unf_q}));
endmodule

// File: rtl/winreg_store.sv
// Physical register storage with combinational read ports and write-first
// forwarding. Row 0 is the hard zero register: never written, reads 0.
module winreg_store #(
    parameter int NPHYS = 136,
    parameter int IDX_W = 8,
    parameter int DW    = 32,
    parameter int NRD   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic [IDX_W-1:0] rd_idx  [NRD],
    output logic [DW-1:0]    rd_data [NRD]
);
    logic [DW-1:0] mem [NPHYS];
    logic          wr_ok;

    // Writes to row 0 are dropped
    always_comb wr_ok = wr_en && (wr_idx != '0);

    // Storage update, cleared on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPHYS; i++)
                mem[i] <= '0;
        end else if (wr_ok) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Read muxes with zero row and same-cycle forwarding
    always_comb begin
        for (int p = 0; p < NRD; p++) begin
            if (rd_idx[p] == '0)
                rd_data[p] = '0;
            else if (wr_ok && (wr_idx == rd_idx[p]))
                rd_data[p] = wr_data;
            else
                rd_data[p] = mem[rd_idx[p]];
        end
    end
endmodule

// File: rtl/winreg_file.sv
// Top of the windowed register file: three address mappers (two reads,
// one write), the window controller and the storage. The write mapper uses
// the pointer value before any move in the same cycle.
module winreg_file
    import winreg_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [4:0]      rd_addr_a,
    output logic [DW-1:0]   rd_data_a,
    input  logic [4:0]      rd_addr_b,
    output logic [DW-1:0]   rd_data_b,
    input  logic            wr_en,
    input  logic [4:0]      wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic            save_req,
    input  logic            restore_req,
    input  logic            mask_we,
    input  logic [NWIN-1:0] mask_wdata,
    output logic [4:0]      cwp,
    output logic            trap_overflow,
    output logic            trap_underflow
);
    localparam int NPHYS = NGLOB + WIN_REGS * NWIN;
    localparam int IDX_W = $clog2(NPHYS);
    localparam int NMAP  = 3;   // read A, read B, write

    logic [CWP_W-1:0] cwp_q;
    logic [AW-1:0]    map_addr [NMAP];
    logic [IDX_W-1:0] map_idx  [NMAP];
    logic [IDX_W-1:0] rd_idx   [2];
    logic [DW-1:0]    rd_data  [2];

    // Gather the addresses each mapper translates
    always_comb begin
        map_addr[0] = rd_addr_a;
        map_addr[1] = rd_addr_b;
        map_addr[2] = wr_addr;
        rd_idx[0]   = map_idx[0];
        rd_idx[1]   = map_idx[1];
    end

    generate
        for (genvar m = 0; m < NMAP; m++) begin : g_map
            winreg_map #(.NWIN(NWIN), .IDX_W(IDX_W)) u_map (
                .arch_addr (map_addr[m]),
                .cwp       (cwp_q),
                .phys_idx  (map_idx[m])
            );
        end
    endgenerate

    winreg_ctrl #(.NWIN(NWIN)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .save_req    (save_req),
        .restore_req (restore_req),
        .mask_we     (mask_we),
        .mask_wdata  (mask_wdata),
        .cwp_q       (cwp_q),
        .ovf_q       (trap_overflow),
        .unf_q       (trap_underflow)
    );

    winreg_store #(.NPHYS(NPHYS), .IDX_W(IDX_W), .DW(DW), .NRD(2)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (map_idx[2]),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    // Drive outputs
    always_comb begin
        rd_data_a = rd_data[0];
        rd_data_b = rd_data[1];
        cwp       = cwp_q;
    end

    assert_zero_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_b == 5'd0) |-> (rd_data_b == '0));
    assert_write_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == rd_addr_a) && (wr_addr != 5'd0)) |-> (rd_data_a == wr_data));
endmodule

// File: tb/winreg_file_tb.sv
// Scoreboard bench: driver tasks queue expected values tagged with the
// cycle they are due in; a monitor compares them at the falling edge.
module winreg_file_tb;
    localparam int NW = 6;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
    logic [DW-1:0] rd_data_a, rd_data_b, wr_data = '0;
    logic          wr_en = 1'b0, save_req = 1'b0, restore_req = 1'b0, mask_we = 1'b0;
    logic [NW-1:0] mask_wdata = '0;
    logic [4:0]    cwp;
    logic          trap_overflow, trap_underflow;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    int          q_cyc  [$];
    int          q_kind [$];
    logic [31:0] q_exp  [$];
    string       q_tag  [$];
    logic [31:0] act;

    always #5 clk = ~clk;

    winreg_file #(.NWIN(NW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .save_req(save_req), .restore_req(restore_req),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .cwp(cwp), .trap_overflow(trap_overflow), .trap_underflow(trap_underflow)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every item due in this cycle
    always @(negedge clk) begin
        for (int i = q_cyc.size() - 1; i >= 0; i--) begin
            if (q_cyc[i] == cyc) begin
                case (q_kind[i])
                    0: act = rd_data_a;
                    1: act = rd_data_b;
                    2: act = {27'b0, cwp};
                    3: act = {31'b0, trap_overflow};
                    default: act = {31'b0, trap_underflow};
                endcase
                checks++;
                if (act !== q_exp[i]) begin
                    errors++;
                    $display("FAIL %s: kind %0d actual %h expected %h", q_tag[i], q_kind[i], act, q_exp[i]);
                end
                q_cyc.delete(i); q_kind.delete(i); q_exp.delete(i); q_tag.delete(i);
            end
        end
    end

    task automatic push(int c, int k, logic [31:0] e, string t);
        q_cyc.push_back(c); q_kind.push_back(k); q_exp.push_back(e); q_tag.push_back(t);
    endtask

    task automatic tick();
        @(posedge clk); #1;
        wr_en = 1'b0; save_req = 1'b0; restore_req = 1'b0; mask_we = 1'b0;
    endtask

    task automatic do_write(logic [4:0] r, logic [31:0] d);
        wr_en = 1'b1; wr_addr = r; wr_data = d; tick();
    endtask

    task automatic chk_rd(logic [4:0] r, logic [31:0] e, string t);
        rd_addr_a = r; push(cyc, 0, e, t); tick();
    endtask

    task automatic chk_rd2(logic [4:0] ra, logic [31:0] ea, logic [4:0] rb, logic [31:0] eb, string t);
        rd_addr_a = ra; rd_addr_b = rb; push(cyc, 0, ea, t); push(cyc, 1, eb, t); tick();
    endtask

    // Issue save/restore; check pointer and trap next cycle, trap gone after
    task automatic do_move(bit s, bit r, int ecwp, bit eo, bit eu, string t);
        save_req = s; restore_req = r;
        push(cyc + 1, 2, ecwp, t);
        push(cyc + 1, 3, {31'b0, eo}, t);
        push(cyc + 1, 4, {31'b0, eu}, t);
        push(cyc + 2, 3, 0, t);
        push(cyc + 2, 4, 0, t);
        push(cyc + 2, 2, ecwp, t);
        tick(); tick();
    endtask

    task automatic load_mask(logic [NW-1:0] m);
        mask_we = 1'b1; mask_wdata = m; tick();
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    // Driver
    initial begin
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1;
        // R1: reset state
        push(cyc, 2, 0, "R1"); push(cyc, 3, 0, "R1"); push(cyc, 4, 0, "R1");
        chk_rd2(5'd5, 0, 5'd20, 0, "R1");
        chk_rd2(5'd12, 0, 5'd30, 0, "R1");
        // R2: writes to register 0 are dropped
        do_write(5'd0, 32'hDEAD);
        chk_rd(5'd0, 0, "R2");
        // Fill globals and all classes of window 0
        for (int i = 1; i < 8; i++) do_write(5'(i), 32'h100 + i);
        for (int k = 0; k < 8; k++) begin
            do_write(5'(8 + k),  32'h2000 + k);
            do_write(5'(16 + k), 32'h1000 + k);
            do_write(5'(24 + k), 32'h3000 + k);
        end
        // R6: save from 0 wraps to NW-1
        do_move(1, 0, NW - 1, 0, 0, "R6 save wrap");
        // R5 and R4: callee ins are caller outs, locals are fresh
        for (int k = 0; k < 8; k++)
            chk_rd2(5'(24 + k), 32'h2000 + k, 5'(16 + k), 0, "R5 R4");
        chk_rd2(5'd3, 32'h103, 5'd7, 32'h107, "R3");
        do_write(5'd16, 32'h5555);
        // R6: restore from NW-1 wraps to 0
        do_move(0, 1, 0, 0, 0, "R6 restore wrap");
        chk_rd2(5'd16, 32'h1000, 5'd8, 32'h2000, "R4 locals private");
        do_move(0, 1, 1, 0, 0, "R6 restore");
        // R5: outs of window 1 are the ins of window 0
        chk_rd2(5'd8, 32'h3000, 5'd15, 32'h3007, "R5");
        chk_rd(5'd3, 32'h103, "R3");
        // R7: save onto masked window 0
        load_mask(6'b000001);
        do_move(1, 0, 1, 1, 0, "R7");
        // R8: restore onto masked window 2
        load_mask(6'b000101);
        do_move(0, 1, 1, 0, 1, "R8");
        // R9: both commands, save wins and traps
        do_move(1, 1, 1, 1, 0, "R9 save priority trap");
        load_mask(6'b000000);
        do_move(1, 1, 0, 0, 0, "R9 save priority move");
        // R10: same-cycle forwarding
        wr_en = 1'b1; wr_addr = 5'd9; wr_data = 32'hABCD;
        chk_rd2(5'd9, 32'hABCD, 5'd10, 32'h2002, "R10");
        chk_rd(5'd9, 32'hABCD, "R10 stored");
        wr_en = 1'b1; wr_addr = 5'd0; wr_data = 32'hFFFF;
        chk_rd2(5'd0, 0, 5'd0, 0, "R2 same cycle");
        // R11: write with a save goes to the old window
        wr_en = 1'b1; wr_addr = 5'd16; wr_data = 32'h7777;
        do_move(1, 0, NW - 1, 0, 0, "R11");
        chk_rd(5'd16, 32'h5555, "R11 new window untouched");
        do_move(0, 1, 0, 0, 0, "R11");
        chk_rd(5'd16, 32'h7777, "R11 old window written");
        // R12: mask load with save uses old mask
        mask_we = 1'b1; mask_wdata = 6'b100000;
        do_move(1, 0, NW - 1, 0, 0, "R12 old mask");
        do_move(0, 1, 0, 0, 0, "R12");
        do_move(1, 0, 0, 1, 0, "R12 new mask");
        tick(); tick();
        if (q_cyc.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", q_cyc.size());
        end
        done = 1'b1;
        finish_run();
    end
endmodule